// File: doc/BRIEF.md
# SCSI Target Data-In Handshake Engine

This block drives the target end of a SCSI data-in transfer. A command sequencer pulses `start` with a byte count and a data setup delay. The engine captures both values in that cycle. It then puts the bus into the data-in phase and sends the requested number of bytes, which it takes one at a time from a transmit FIFO. Each byte travels over the asynchronous REQ/ACK handshake. The CPU may still be filling the FIFO after the command begins. Because the count was captured at `start`, those later writes do not disturb it.

For each byte the engine does four things. It pops the byte and drives it onto the data lines. It waits the programmed setup time, then asserts REQ. It waits for a synchronized ACK, then negates REQ. It waits for ACK to negate before it touches the next byte. When the FIFO is empty the engine sits with REQ negated until a byte arrives. After the final handshake it releases the bus and pulses `done`, so the sequencer can post its good-completion status and interrupt. All SCSI lines are active low: a 0 on a `_n` port means the signal is asserted.

Top module: `scsi_din_target`

## Requirements
- R1: While reset is held and after it is released, `scsi_req_n`, `scsi_io_n`, `scsi_cd_n`, `scsi_msg_n` and every bit of `scsi_db_n` are 1, and `done` and `busy` are 0.
- R2: After a `start` with a nonzero count, the phase lines show the data-in phase before the first REQ: `scsi_io_n`=0, `scsi_cd_n`=1, `scsi_msg_n`=1. They hold these values for every REQ of the transfer.
- R3: A transfer sends exactly the captured count of bytes, in FIFO order. Each FIFO entry is popped exactly once. Each byte appears inverted on `scsi_db_n`.
- R4: `fifo_rd` is raised only when `fifo_empty` is 0. While no byte is available, REQ stays negated and `busy` stays 1. The transfer resumes once the FIFO has data.
- R5: `byte_count` and `setup_clks` are captured only on a `start` seen while idle. Changes to those inputs after that, and a `start` while busy, have no effect on the transfer.
- R6: REQ is asserted exactly S clocks after the clock edge that loads the byte onto the data lines. S is the captured `setup_clks`, and a value of 0 counts as 1. The data lines stay stable while REQ is asserted.
- R7: REQ is negated only after ACK has been seen asserted. The next byte is loaded only after ACK has been seen negated again.
- R8: When the last byte's ACK negates, `done` pulses for one cycle with the bus already released. `busy` drops in the following cycle.
- R9: A `start` with a count of 0 produces a `done` pulse and no REQ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle command start pulse |
| byte_count | input | 16 | Number of bytes to send, sampled at start |
| setup_clks | input | 4 | Clocks from data valid to REQ (0 treated as 1), sampled at start |
| fifo_empty | input | 1 | Transmit FIFO has no data |
| fifo_data | input | 8 | Head entry of the transmit FIFO |
| fifo_rd | output | 1 | Pop the FIFO head this cycle |
| scsi_ack_n | input | 1 | ACK from the initiator, asynchronous, active low |
| scsi_req_n | output | 1 | REQ to the initiator, active low |
| scsi_io_n | output | 1 | I/O phase line, active low |
| scsi_cd_n | output | 1 | C/D phase line, active low |
| scsi_msg_n | output | 1 | MSG phase line, active low |
| scsi_db_n | output | 8 | Data lines, active low |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse when the transfer completes |

## Verification
The assertions assume the initiator follows the handshake. It never asserts ACK unless REQ is asserted, and it holds ACK asserted until it has seen REQ negate. The checker also assumes that `fifo_data` is valid whenever `fifo_empty` is 0.

The bench's initiator model is a small state machine that reacts only to REQ edges and adds a random delay of 0 to 3 cycles before each ACK change. The bench's FIFO model changes its flag and head entry only on the falling clock edge. The stimulus therefore never breaks these assumptions, while REQ/ACK timing and FIFO starvation still vary from run to run.

// File: rtl/scsi_din_pkg.sv
// Package: shared types for the target data-in engine.
// Assumes: included ahead of every module of this block.
package scsi_din_pkg;

    // Sequencer states of the engine
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PHASE   = 3'd1,
        ST_FETCH   = 3'd2,
        ST_SETUP   = 3'd3,
        ST_REQ     = 3'd4,
        ST_RELEASE = 3'd5,
        ST_DONE    = 3'd6
    } din_state_e;

    // Bus phase lines as asserted-high flags
    typedef struct packed {
        logic msg;
        logic cd;
        logic io;
    } phase_lines_t;

    // Data-in: I/O asserted, C/D and MSG negated
    localparam phase_lines_t PH_DATA_IN = '{msg: 1'b0, cd: 1'b0, io: 1'b1};
    localparam phase_lines_t PH_FREE    = '{msg: 1'b0, cd: 1'b0, io: 1'b0};

endpackage

// File: rtl/scsi_din_sync.sv
// Module: multi-flop synchronizer for an asynchronous active-low input.
// Assumes: input may change at any time; the output is valid STAGES clocks later.
module scsi_din_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    // Shift the input through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/scsi_din_timer.sv
// Module: loadable down-counter for the data-to-REQ setup delay.
// Assumes: load and run are never both high; a load value of 0 means 1.
module scsi_din_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         expire
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] eff_val;

    // A zero setting still waits one clock
    always_comb eff_val = (load_val == '0) ? W'(1) : load_val;

    // Load the delay, then count down while running
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (load)                   cnt_q <= eff_val;
        else if (run && cnt_q != '0)     cnt_q <= cnt_q - W'(1);
    end

    assign expire = run && (cnt_q == W'(1));
endmodule

// File: rtl/scsi_din_counter.sv
// Module: remaining-byte counter, captured once per command.
// Assumes: dec is pulsed once per completed handshake; never decremented at 0.
module scsi_din_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last
);
    logic [W-1:0] left_q;

    // Capture the count at start and decrement per byte
    always_ff @(posedge clk) begin
        if (!rst_n)                 left_q <= '0;
        else if (load)              left_q <= load_val;
        else if (dec && left_q != '0) left_q <= left_q - W'(1);
    end

    assign last = (left_q == W'(1));
endmodule

// File: rtl/scsi_din_target.sv
// Module: target-side data-in engine. Drives the data-in phase, moves a
// captured number of bytes from a FIFO with the REQ/ACK handshake, and
// stalls with REQ negated while the FIFO is empty.
// Assumes: start is a one-cycle pulse; the initiator holds ACK until REQ
// negates; fifo_data is valid whenever fifo_empty is low.
module scsi_din_target
    import scsi_din_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int DATA_W   = 8,
    parameter int SETUP_W  = 4,
    parameter int SYNC_LEN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic [SETUP_W-1:0] setup_clks,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              fifo_rd,
    input  logic              scsi_ack_n,
    output logic              scsi_req_n,
    output logic              scsi_io_n,
    output logic              scsi_cd_n,
    output logic              scsi_msg_n,
    output logic [DATA_W-1:0] scsi_db_n,
    output logic              busy,
    output logic              done
);
    din_state_e        state_q;
    logic [SETUP_W-1:0] setup_q;
    logic [DATA_W-1:0] data_q;
    logic              req_q;
    phase_lines_t      phase_q;
    logic              ack_sync_n;
    logic              ack_seen;
    logic              take_start;
    logic              zero_count;
    logic              timer_load;
    logic              timer_run;
    logic              timer_done;
    logic              cnt_dec;
    logic              cnt_last;
    logic              ack_gone;

    // ACK arrives asynchronously; bring it into the clock domain
    scsi_din_sync #(.STAGES(SYNC_LEN), .RESET_VAL(1'b1)) u_ack_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (scsi_ack_n),
        .sync_out (ack_sync_n)
    );

    assign ack_seen = !ack_sync_n;

    // Decode the per-cycle controls from the state
    always_comb begin
        take_start = (state_q == ST_IDLE) && start;
        zero_count = (byte_count == '0);
        fifo_rd    = (state_q == ST_FETCH) && !fifo_empty;
        timer_load = fifo_rd;
        timer_run  = (state_q == ST_SETUP);
        ack_gone   = (state_q == ST_RELEASE) && !ack_seen;
        cnt_dec    = ack_gone;
    end

    scsi_din_timer #(.W(SETUP_W)) u_setup_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (setup_q),
        .run      (timer_run),
        .expire   (timer_done)
    );

    scsi_din_counter #(.W(CNT_W)) u_byte_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take_start),
        .load_val (byte_count),
        .dec      (cnt_dec),
        .last     (cnt_last)
    );

    // Capture the setup delay with the command
    always_ff @(posedge clk) begin
        if (!rst_n)          setup_q <= '0;
        else if (take_start) setup_q <= setup_clks;
    end

    // Handshake sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            req_q   <= 1'b0;
            data_q  <= '0;
            phase_q <= PH_FREE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (take_start) begin
                        if (zero_count) begin
                            state_q <= ST_DONE;
                        end else begin
                            state_q <= ST_PHASE;
                            phase_q <= PH_DATA_IN;
                        end
                    end
                end
                ST_PHASE: state_q <= ST_FETCH;
                ST_FETCH: begin
                    if (fifo_rd) begin
                        data_q  <= fifo_data;
                        state_q <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (timer_done) begin
                        req_q   <= 1'b1;
                        state_q <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (ack_seen) begin
                        req_q   <= 1'b0;
                        state_q <= ST_RELEASE;
                    end
                end
                ST_RELEASE: begin
                    if (ack_gone) begin
                        if (cnt_last) begin
                            state_q <= ST_DONE;
                            phase_q <= PH_FREE;
                            data_q  <= '0;
                        end else begin
                            state_q <= ST_FETCH;
                        end
                    end
                end
                ST_DONE:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the active-low bus from the asserted-high registers
    always_comb begin
        scsi_req_n = !req_q;
        scsi_io_n  = !phase_q.io;
        scsi_cd_n  = !phase_q.cd;
        scsi_msg_n = !phase_q.msg;
        scsi_db_n  = ~data_q;
        busy       = (state_q != ST_IDLE);
        done       = (state_q == ST_DONE);
    end
endmodule

// File: rtl/scsi_din_target_chk.sv
// Module: protocol checker bound to the data-in engine.
// Assumes: initiator holds ACK asserted until REQ negates.
module scsi_din_target_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              fifo_rd,
    input logic              fifo_empty,
    input logic              scsi_ack_n,
    input logic              scsi_req_n,
    input logic              scsi_io_n,
    input logic              scsi_cd_n,
    input logic              scsi_msg_n,
    input logic [DATA_W-1:0] scsi_db_n
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> scsi_req_n && scsi_io_n);

    assert_req_in_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !scsi_req_n |-> !scsi_io_n && scsi_cd_n && scsi_msg_n);

    assert_pop_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> !fifo_empty && scsi_req_n);

    assert_data_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!scsi_req_n && !$past(scsi_req_n)) |-> $stable(scsi_db_n));

    assert_req_drop_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!scsi_req_n) && scsi_req_n) |-> $past(!scsi_ack_n));

    assert_done_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> scsi_req_n && scsi_io_n && (scsi_db_n == '1));

    assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

bind scsi_din_target scsi_din_target_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .fifo_rd    (fifo_rd),
    .fifo_empty (fifo_empty),
    .scsi_ack_n (scsi_ack_n),
    .scsi_req_n (scsi_req_n),
    .scsi_io_n  (scsi_io_n),
    .scsi_cd_n  (scsi_cd_n),
    .scsi_msg_n (scsi_msg_n),
    .scsi_db_n  (scsi_db_n)
);

// File: tb/sim_scsi_din_target.sv
// Bench: FIFO model, initiator model and scoreboard for the data-in engine.
module sim_scsi_din_target;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] byte_count = '0;
    logic [3:0]  setup_clks = '0;
    logic        fifo_empty = 1'b1;
    logic [7:0]  fifo_data = '0;
    logic        fifo_rd;
    logic        scsi_ack_n = 1'b1;
    logic        scsi_req_n, scsi_io_n, scsi_cd_n, scsi_msg_n;
    logic [7:0]  scsi_db_n;
    logic        busy, done;

    int total = 0;
    int bad = 0;

    scsi_din_target u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
        .setup_clks(setup_clks), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
        .fifo_rd(fifo_rd), .scsi_ack_n(scsi_ack_n), .scsi_req_n(scsi_req_n),
        .scsi_io_n(scsi_io_n), .scsi_cd_n(scsi_cd_n), .scsi_msg_n(scsi_msg_n),
        .scsi_db_n(scsi_db_n), .busy(busy), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Scoreboard state
    logic [7:0] fifo_q[$];
    logic [7:0] pend_q[$];
    logic [7:0] exp_q[$];
    logic [7:0] rx_q[$];
    int  cyc = 0;
    logic pop_pending = 1'b0;
    int  t_load = 0;
    int  setup_eff = 1;
    int  feed_rate = 100;
    bit  feed_on = 1'b1;
    int  done_cnt = 0;
    int  req_falls = 0;
    logic prev_req_n = 1'b1;
    int  ini_state = 0;
    int  ini_dly = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Effective setup delay from the requirement: 0 counts as 1
    function automatic int eff_setup(input int s);
        return (s == 0) ? 1 : s;
    endfunction

    // Record pops and count cycles on the active edge
    always @(posedge clk) begin
        cyc         <= cyc + 1;
        pop_pending <= fifo_rd;
    end

    // FIFO model, initiator model and monitors, all away from the active edge
    always @(negedge clk) begin
        if (pop_pending) begin
            if (fifo_q.size() > 0) void'(fifo_q.pop_front());
            t_load = cyc;
        end
        if (feed_on && pend_q.size() > 0 && $urandom_range(99) < feed_rate)
            fifo_q.push_back(pend_q.pop_front());
        fifo_empty = (fifo_q.size() == 0);
        fifo_data  = fifo_empty ? 8'h00 : fifo_q[0];

        if (rst_n && prev_req_n && !scsi_req_n) begin
            req_falls++;
            // R6: REQ comes exactly the setup delay after the data load
            check((cyc - t_load) == setup_eff, "R6 setup clocks", cyc - t_load, setup_eff);
            // R2: data-in phase lines while REQ is asserted
            check(!scsi_io_n && scsi_cd_n && scsi_msg_n, "R2 phase lines",
                  {scsi_msg_n, scsi_cd_n, scsi_io_n}, 3'b110);
        end
        prev_req_n = scsi_req_n;
        if (done) done_cnt++;

        // Initiator: wait REQ, ACK, wait REQ negate, release ACK
        case (ini_state)
            0: if (!scsi_req_n) begin
                   rx_q.push_back(~scsi_db_n);
                   ini_dly = $urandom_range(3);
                   ini_state = 1;
               end
            1: if (ini_dly == 0) begin scsi_ack_n = 1'b0; ini_state = 2; end
               else ini_dly--;
            2: if (scsi_req_n) begin ini_dly = $urandom_range(3); ini_state = 3; end
            default: if (ini_dly == 0) begin scsi_ack_n = 1'b1; ini_state = 0; end
                     else ini_dly--;
        endcase
    end

    task automatic pulse_start(input int n, input int s);
        @(negedge clk);
        byte_count = 16'(n);
        setup_clks = 4'(s);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        byte_count = 16'($urandom_range(200));
        setup_clks = 4'($urandom_range(15));
    endtask

    // One transfer: optional starvation hold and mid-transfer disturbance
    task automatic run_xfer(input int n, input int s, input int rate,
                            input bit hold, input bit disturb);
        int guard;
        rx_q.delete();
        exp_q.delete();
        done_cnt  = 0;
        req_falls = 0;
        feed_rate = rate;
        setup_eff = eff_setup(s);
        feed_on   = !hold;
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = 8'($urandom_range(255));
            exp_q.push_back(b);
            pend_q.push_back(b);
        end
        pulse_start(n, s);
        if (hold) begin
            repeat (40) @(negedge clk);
            // R4: no byte available, REQ held off and engine still busy
            check(scsi_req_n && busy && req_falls == 0, "R4 stall on empty",
                  {scsi_req_n, busy}, 2'b11);
            feed_on = 1'b1;
        end
        if (disturb) begin
            repeat (6) @(negedge clk);
            start = 1'b1;
            byte_count = 16'(n + 7);
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (done_cnt == 0 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
        check(done_cnt == 1, "R8 one done pulse", done_cnt, 1);
        check(!busy && scsi_req_n && scsi_io_n && scsi_db_n == 8'hFF,
              "R8 bus released", {busy, scsi_req_n, scsi_io_n}, 3'b011);
        // R3/R5: exactly the captured count, in FIFO order
        check(rx_q.size() == n, disturb ? "R5 count captured" : "R3 byte count",
              rx_q.size(), n);
        for (int i = 0; i < n && i < rx_q.size(); i++)
            check(rx_q[i] == exp_q[i], "R3 byte order", rx_q[i], exp_q[i]);
        check(fifo_q.size() == 0 && pend_q.size() == 0, "R3 all popped once",
              fifo_q.size(), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: outputs quiet during reset
        check(scsi_req_n && scsi_io_n && scsi_cd_n && scsi_msg_n && scsi_db_n == 8'hFF
              && !done && !busy, "R1 reset state", {scsi_req_n, busy, done}, 3'b100);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(scsi_req_n && scsi_io_n && !busy && !done, "R1 after reset",
              {scsi_req_n, scsi_io_n, busy}, 3'b110);

        // R9: zero count gives done without REQ
        done_cnt = 0;
        req_falls = 0;
        pulse_start(0, 5);
        repeat (4) @(negedge clk);
        check(done_cnt == 1 && req_falls == 0, "R9 zero count", done_cnt * 10 + req_falls, 10);

        run_xfer(3, 0, 100, 1'b1, 1'b0);    // R4 starvation, setup 0
        run_xfer(4, 15, 100, 1'b0, 1'b1);   // R5 late start and count change
        run_xfer(1, 1, 100, 1'b0, 1'b0);    // single byte
        for (int k = 0; k < 20; k++)
            run_xfer($urandom_range(12) + 1, $urandom_range(15),
                     $urandom_range(80) + 20, 1'b0, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial void'($urandom(32'd1234));
endmodule